// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

The block turns a vector of per-cycle hit flags from match units into one trigger event. It walks a chain of up to sixteen levels. Only the current level is evaluated. When its condition holds at a clock edge, the next level becomes current. When the final level is satisfied, the block records a triggered status and launches the event into a fixed delay line. The delay line drives an external trigger pin.

Each level carries a mask that picks which hit flags it looks at, and a mode bit that chooses between "any selected hit" and "all selected hits". The trigger pin can be a held level or a one-cycle pulse, and it can be active-high or active-low. Both choices can be changed while the block is running. The arm input starts a capture: holding it high lets the chain run, and dropping it returns everything to the start. The remaining configuration is expected to stay static while armed.

Top module: `trig_seq_top`

## Requirements
- R1: While rst_n is low and after reset, cur_level is 0, triggered is 0 and trig_out sits at its inactive value, which equals cfg_out_low.
- R2: Bit i of the mask slice for level L (cfg_lvl_mask[L*NUM_HITS+i]) selects hit bit i. If cfg_lvl_all[L] is 0, the level is met when any selected hit is 1. If cfg_lvl_all[L] is 1, the level is met only when every selected hit is 1. A level with an all-zero mask is never met.
- R3: While arm is high and triggered is 0, a clock edge at which the current level is met raises cur_level by exactly one. An edge at which it is not met leaves cur_level unchanged. The level never moves by more than one per cycle.
- R4: The chain has cfg_last_lvl+1 levels (1 to 16). When level cfg_last_lvl is met at an edge, triggered becomes 1 after that edge and cur_level stays at cfg_last_lvl.
- R5: The active value of trig_out first appears after the tenth clock edge following the edge that set triggered, and not earlier.
- R6: trig_out equals the internal active flag XOR cfg_out_low, so 0 selects active-high and 1 selects active-low. A change of cfg_out_low takes effect on trig_out without waiting for a clock.
- R7: With cfg_out_pulse at 0, trig_out stays active until disarm. With cfg_out_pulse at 1, it is active for exactly one cycle.
- R8: Once triggered is 1, further hits change neither cur_level, nor triggered, nor the trig_out waveform.
- R9: A clock edge with arm low sets cur_level to 0 and triggered to 0, discards any event still in the delay line, and returns trig_out to inactive. Hits seen while arm is low advance nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm | input | 1 | High to run the sequence; low returns to level 0 |
| hit_i | input | NUM_HITS | Per-cycle match-unit hit flags |
| cfg_last_lvl | input | LVL_W | Index of the final level (levels minus one) |
| cfg_lvl_mask | input | NUM_HITS*MAX_LEVELS | Hit-select mask per level, level L at bits L*NUM_HITS upward |
| cfg_lvl_all | input | MAX_LEVELS | Per level: 1 requires all selected hits, 0 any |
| cfg_out_low | input | 1 | 1 makes trig_out active-low |
| cfg_out_pulse | input | 1 | 1 gives a one-cycle pulse, 0 a held level |
| trig_out | output | 1 | Delayed external trigger |
| triggered | output | 1 | Final level has been satisfied since arming |
| cur_level | output | LVL_W | Level currently being evaluated |

## Verification
The properties assume that the level masks, the AND/ANY bits and cfg_last_lvl do not change while arm is high. They also assume the form bit stays put for the cycle after the output turns active, and that arm stays high across the whole delay window whenever latency is being judged. The directed tasks rewrite configuration only while arm is low. They toggle polarity only while the output is already held. They drop arm only at a negative clock edge, so every run from arming to firing sees one fixed setup.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic {
    SEQ_HUNT  = 1'b0,
    SEQ_FIRED = 1'b1
  } seq_state_e;

  // next value of the internal active flag of the output stage
  function automatic logic form_next(input logic held, input logic fresh,
                                     input logic pulse_mode);
    return pulse_mode ? fresh : (held | fresh);
  endfunction

endpackage

// File: rtl/trig_seq_cond.sv
module trig_seq_cond #(
  parameter int NUM_HITS   = 16,
  parameter int MAX_LEVELS = 16
) (
  input  logic [NUM_HITS-1:0]            hit_i,
  input  logic [NUM_HITS*MAX_LEVELS-1:0] cfg_lvl_mask,
  input  logic [MAX_LEVELS-1:0]          cfg_lvl_all,
  output logic [MAX_LEVELS-1:0]          level_met
);

  function automatic logic eval_level(input logic [NUM_HITS-1:0] hits,
                                      input logic [NUM_HITS-1:0] mask,
                                      input logic                need_all);
    logic [NUM_HITS-1:0] sel;
    sel = hits & mask;
    if (mask == '0) return 1'b0;
    return need_all ? (sel == mask) : (|sel);
  endfunction

  for (genvar l = 0; l < MAX_LEVELS; l++) begin : g_lvl
    assign level_met[l] = eval_level(hit_i,
                                     cfg_lvl_mask[l*NUM_HITS +: NUM_HITS],
                                     cfg_lvl_all[l]);
  end

endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_seq_pkg::*;
#(
  parameter int MAX_LEVELS = 16,
  parameter int LVL_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm,
  input  logic [MAX_LEVELS-1:0] level_met,
  input  logic [LVL_W-1:0]      cfg_last_lvl,
  output logic [LVL_W-1:0]      cur_level,
  output logic                  triggered,
  output logic                  advance,
  output logic                  trig_evt
);

  seq_state_e state_q;
  logic       hunting;
  logic       lvl_met;
  logic       at_last;

  assign hunting  = arm && (state_q == SEQ_HUNT);
  assign lvl_met  = level_met[cur_level];
  assign at_last  = (cur_level == cfg_last_lvl);
  assign advance  = hunting && lvl_met && !at_last;
  assign trig_evt = hunting && lvl_met && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      state_q   <= SEQ_HUNT;
      cur_level <= '0;
    end else if (trig_evt) begin
      state_q   <= SEQ_FIRED;
    end else if (advance) begin
      cur_level <= cur_level + 1'b1;
    end
  end

  assign triggered = (state_q == SEQ_FIRED);

endmodule

// File: rtl/trig_seq_outdly.sv
module trig_seq_outdly
  import trig_seq_pkg::*;
#(
  parameter int OUT_DELAY = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic trig_evt,
  input  logic cfg_out_pulse,
  output logic out_act
);

  logic dly_last;

  if (OUT_DELAY > 1) begin : g_chain
    logic [OUT_DELAY-1:0] dly_q;
    always_ff @(posedge clk) begin
      if (!rst_n || !arm) dly_q <= '0;
      else                dly_q <= {dly_q[OUT_DELAY-2:0], trig_evt};
    end
    assign dly_last = dly_q[OUT_DELAY-1];
  end else begin : g_single
    logic dly_q;
    always_ff @(posedge clk) begin
      if (!rst_n || !arm) dly_q <= 1'b0;
      else                dly_q <= trig_evt;
    end
    assign dly_last = dly_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) out_act <= 1'b0;
    else                out_act <= form_next(out_act, dly_last, cfg_out_pulse);
  end

endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top #(
  parameter int NUM_HITS   = 16,
  parameter int MAX_LEVELS = 16,
  parameter int OUT_DELAY  = 10,
  localparam int LVL_W     = $clog2(MAX_LEVELS),
  localparam int MASK_W    = NUM_HITS * MAX_LEVELS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm,
  input  logic [NUM_HITS-1:0]   hit_i,
  input  logic [LVL_W-1:0]      cfg_last_lvl,
  input  logic [MASK_W-1:0]     cfg_lvl_mask,
  input  logic [MAX_LEVELS-1:0] cfg_lvl_all,
  input  logic                  cfg_out_low,
  input  logic                  cfg_out_pulse,
  output logic                  trig_out,
  output logic                  triggered,
  output logic [LVL_W-1:0]      cur_level
);

  logic [MAX_LEVELS-1:0] level_met;
  logic                  advance;
  logic                  trig_evt;
  logic                  out_act;

  trig_seq_cond #(.NUM_HITS(NUM_HITS), .MAX_LEVELS(MAX_LEVELS)) cond_i (
    .hit_i        (hit_i),
    .cfg_lvl_mask (cfg_lvl_mask),
    .cfg_lvl_all  (cfg_lvl_all),
    .level_met    (level_met)
  );

  trig_seq_fsm #(.MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W)) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (arm),
    .level_met    (level_met),
    .cfg_last_lvl (cfg_last_lvl),
    .cur_level    (cur_level),
    .triggered    (triggered),
    .advance      (advance),
    .trig_evt     (trig_evt)
  );

  trig_seq_outdly #(.OUT_DELAY(OUT_DELAY)) outdly_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm           (arm),
    .trig_evt      (trig_evt),
    .cfg_out_pulse (cfg_out_pulse),
    .out_act       (out_act)
  );

  assign trig_out = out_act ^ cfg_out_low;

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int OUT_DELAY = 10,
  parameter int LVL_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             cfg_out_pulse,
  input logic [LVL_W-1:0] cfg_last_lvl,
  input logic [LVL_W-1:0] cur_level,
  input logic             triggered,
  input logic             advance,
  input logic             trig_evt,
  input logic             out_act
);

  localparam int CW = $clog2(OUT_DELAY + 2);
  localparam logic [CW-1:0] SAT = CW'(OUT_DELAY + 1);
  localparam logic [CW-1:0] DLY = CW'(OUT_DELAY);

  logic [CW-1:0] since_fire;

  always_ff @(posedge clk) begin
    if (!rst_n || !arm)                       since_fire <= '0;
    else if (triggered && since_fire != SAT)  since_fire <= since_fire + 1'b1;
  end

  // R3: at most one level per cycle
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cur_level == $past(cur_level)) || (cur_level == $past(cur_level) + 1'b1));

  p_adv_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> cur_level == $past(cur_level) + 1'b1);

  p_adv_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && trig_evt));

  // R4: firing happens on the final level
  p_fire_last_r4: assert property (@(posedge clk) disable iff (!rst_n || !arm)
    $rose(triggered) |-> cur_level == cfg_last_lvl);

  // R5: no early output, output present at the delay boundary
  p_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n || !arm)
    (!triggered || since_fire < DLY) |-> !out_act);

  p_on_time_r5: assert property (@(posedge clk) disable iff (!rst_n || !arm)
    (triggered && since_fire == DLY) |-> out_act);

  // R7: pulse lasts one cycle, level holds
  p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_n || !arm)
    (out_act && cfg_out_pulse) |=> !out_act);

  p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || !arm)
    (out_act && !cfg_out_pulse) |=> out_act);

  // R8: triggered state is sticky and frozen
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && triggered) |=> (triggered && cur_level == $past(cur_level)));

  // R9: disarm clears everything
  p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (cur_level == '0 && !triggered && !out_act));

endmodule

bind trig_seq_top trig_seq_chk #(.OUT_DELAY(OUT_DELAY), .LVL_W(LVL_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .arm           (arm),
  .cfg_out_pulse (cfg_out_pulse),
  .cfg_last_lvl  (cfg_last_lvl),
  .cur_level     (cur_level),
  .triggered     (triggered),
  .advance       (advance),
  .trig_evt      (trig_evt),
  .out_act       (out_act)
);

// File: tb/trig_seq_top_tb_top.sv
`timescale 1ns/1ps
module trig_seq_top_tb_top;

  localparam int NH  = 16;
  localparam int NL  = 16;
  localparam int DLY = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           arm = 1'b0;
  logic [NH-1:0]  hit = '0;
  logic [3:0]     cfg_last = '0;
  logic [NH*NL-1:0] cfg_mask = '0;
  logic [NL-1:0]  cfg_all = '0;
  logic           pol = 1'b0;
  logic           pulse = 1'b0;
  logic           trig_out;
  logic           triggered;
  logic [3:0]     cur_level;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trig_seq_top dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm           (arm),
    .hit_i         (hit),
    .cfg_last_lvl  (cfg_last),
    .cfg_lvl_mask  (cfg_mask),
    .cfg_lvl_all   (cfg_all),
    .cfg_out_low   (pol),
    .cfg_out_pulse (pulse),
    .trig_out      (trig_out),
    .triggered     (triggered),
    .cur_level     (cur_level)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int active();
    return int'(trig_out ^ pol);
  endfunction

  task automatic set_lvl(input int l, input logic [NH-1:0] m, input logic all);
    cfg_mask[l*NH +: NH] = m;
    cfg_all[l] = all;
  endtask

  task automatic disarm_cfg();
    arm = 1'b0; hit = '0;
    tick();
    cfg_mask = '0; cfg_all = '0;
  endtask

  // fire a single-level chain on hit bit b, return after the firing edge
  task automatic fire_one(input int b);
    disarm_cfg();
    cfg_last = 4'd0;
    set_lvl(0, NH'(1) << b, 1'b0);
    arm = 1'b1;
    hit = NH'(1) << b;
    tick();
    hit = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 level", int'(cur_level), 0);
    chk("R1 triggered", int'(triggered), 0);
    chk("R1 trig_out", int'(trig_out), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset trig_out", int'(trig_out), 0);
  endtask

  task automatic t_chain();
    int early;
    disarm_cfg();
    cfg_last = 4'd2; pulse = 1'b0; pol = 1'b0;
    set_lvl(0, 16'h0001, 1'b0);
    set_lvl(1, 16'h0002, 1'b0);
    set_lvl(2, 16'h0004, 1'b0);
    arm = 1'b1;
    hit = 16'h0002; tick();
    chk("R3 wrong hit holds", int'(cur_level), 0);
    hit = 16'h0001; tick();
    chk("R3 advance to 1", int'(cur_level), 1);
    hit = 16'h0000; tick();
    chk("R3 idle holds", int'(cur_level), 1);
    hit = 16'h0003; tick();
    chk("R2 any-of advance to 2", int'(cur_level), 2);
    chk("R4 not yet triggered", int'(triggered), 0);
    hit = 16'h0004; tick();
    hit = 16'h0000;
    chk("R4 triggered", int'(triggered), 1);
    chk("R4 level stays last", int'(cur_level), 2);
    early = 0;
    for (int k = 0; k < DLY - 1; k++) begin
      tick();
      if (active() != 0) early++;
      hit = 16'hFFFF;
    end
    chk("R5 no early output", early, 0);
    tick();
    chk("R5 active at delay", active(), 1);
    repeat (3) tick();
    chk("R7 level held", active(), 1);
    chk("R8 level frozen", int'(cur_level), 2);
    chk("R8 still triggered", int'(triggered), 1);
    hit = '0;
  endtask

  task automatic t_and();
    disarm_cfg();
    cfg_last = 4'd0;
    set_lvl(0, 16'h0030, 1'b1);
    arm = 1'b1;
    hit = 16'h0010; tick();
    chk("R2 all-of partial", int'(triggered), 0);
    hit = 16'h0020; tick();
    chk("R2 all-of other partial", int'(triggered), 0);
    hit = 16'h00F0; tick();
    chk("R2 all-of complete", int'(triggered), 1);
    disarm_cfg();
    cfg_last = 4'd0;
    arm = 1'b1;
    hit = 16'hFFFF; tick();
    chk("R2 empty mask any-of", int'(triggered), 0);
    arm = 1'b0; tick();
    cfg_all[0] = 1'b1;
    arm = 1'b1; tick();
    chk("R2 empty mask all-of", int'(triggered), 0);
    hit = '0;
  endtask

  task automatic t_pulse();
    int early, late;
    pulse = 1'b1;
    fire_one(7);
    early = 0;
    for (int k = 0; k < DLY - 1; k++) begin
      tick();
      if (active() != 0) early++;
    end
    chk("R5 pulse no early", early, 0);
    tick();
    chk("R7 pulse active", active(), 1);
    late = 0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (active() != 0) late++;
    end
    chk("R7 pulse one cycle", late, 0);
    pulse = 1'b0;
  endtask

  task automatic t_polarity();
    disarm_cfg();
    pol = 1'b1;
    #1;
    chk("R6 idle high when active-low", int'(trig_out), 1);
    fire_one(3);
    repeat (DLY) tick();
    chk("R6 active-low asserted", int'(trig_out), 0);
    pol = 1'b0;
    #1;
    chk("R6 run-time flip", int'(trig_out), 1);
  endtask

  task automatic t_disarm();
    int seen;
    fire_one(3);
    repeat (4) tick();
    arm = 1'b0; tick();
    chk("R9 level cleared", int'(cur_level), 0);
    chk("R9 triggered cleared", int'(triggered), 0);
    arm = 1'b1;
    seen = 0;
    for (int k = 0; k < DLY + 2; k++) begin
      tick();
      if (active() != 0) seen++;
    end
    chk("R9 pending event dropped", seen, 0);
    disarm_cfg();
    cfg_last = 4'd3;
    for (int l = 0; l < 4; l++) set_lvl(l, 16'h0100, 1'b0);
    hit = 16'h0100; tick();
    chk("R9 no advance while disarmed", int'(cur_level), 0);
    arm = 1'b1; tick(); tick();
    chk("R3 chain mid-way", int'(cur_level), 2);
    arm = 1'b0; tick();
    chk("R9 mid-chain return", int'(cur_level), 0);
    hit = '0;
  endtask

  task automatic t_full();
    int bad;
    disarm_cfg();
    cfg_last = 4'd15;
    for (int l = 0; l < NL; l++) set_lvl(l, 16'h0200, 1'b0);
    arm = 1'b1;
    hit = 16'h0200;
    bad = 0;
    for (int k = 1; k < NL; k++) begin
      tick();
      if (int'(cur_level) != k || triggered) bad++;
    end
    chk("R3 one level per cycle", bad, 0);
    tick();
    chk("R4 sixteen levels fire", int'(triggered), 1);
    chk("R4 last level index", int'(cur_level), 15);
    hit = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_chain();
    t_and();
    t_pulse();
    t_polarity();
    t_disarm();
    t_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule